// File: doc/BRIEF.md
# Two-Stage Prefetching Instruction Fetch Unit

This unit is the front end of a processor whose program memory sits on its own bus, apart from data memory. Every program word is one complete 16-bit instruction, and the program space holds 512 words. The unit keeps the program counter and drives the program-memory address. The memory answers one clock after it is addressed. While the instruction now at the execute stage is being carried out, the word after it is already being read, so one instruction can issue on every clock.

The execute stage steers the unit in three ways. A taken strobe with a signed 12-bit offset makes a relative jump or call. An absolute-load strobe sends fetch to a given address, which serves for returns. A stall input freezes the unit. The word that was prefetched before a redirect is stale, so it is discarded: for one cycle the execute stage sees a bubble, with the valid flag low and a NOP word. Relative targets wrap modulo 512, so every address can be reached from any other.

Top module: `ifu_top`

## Requirements
- R1: With reset asserted, the unit shows no valid instruction. In the first cycle after reset is released, imemAddr is 0 and instrValid is 0. In the next cycle instrValid is 1, instrPc is 0 and instr is the memory word at address 0.
- R2: With stall, brTaken and absLoad all low, a valid instruction at address P is followed in the next cycle by a valid instruction at (P+1) mod 512. After 511 comes 0.
- R3: In any cycle where stall is low and instrValid is 1, imemAddr equals (instrPc+1) mod 512. The word after the executing one is being prefetched.
- R4: brTaken=1 with instrValid=1 and stall=0 in a cycle where instrPc=P is a relative redirect. Two cycles later the valid instruction is at (P + 1 + brOffset) mod 512, with brOffset read as signed two's complement.
- R5: In the cycle after any taken redirect, instrValid is 0 and instr is 16'h0000, the NOP word.
- R6: absLoad=1 with instrValid=1 and stall=0 redirects fetch to absAddr. The valid instruction appears two cycles later. absLoad wins when brTaken is also high.
- R7: While stall is 1, instr, instrPc and instrValid stay unchanged in the next cycle, and brTaken and absLoad are ignored. Fetch resumes in sequence once stall falls.
- R8: brTaken and absLoad are ignored in a cycle where instrValid is 0. The bubble is followed by the redirect target already in flight.
- R9: Offsets whose size is 512 or more wrap. +2047 from P lands on P. -2048 and +512 each land on P+1. -1 lands on P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold the executing instruction and the PC |
| brTaken | input | 1 | Take a relative jump or call this cycle |
| brOffset | input | 12 | Signed word offset from the address after the executing instruction |
| absLoad | input | 1 | Load the fetch address from absAddr (return) |
| absAddr | input | 9 | Absolute target word address |
| imemAddr | output | 9 | Program-memory word address, read one cycle later |
| imemData | input | 16 | Program-memory read data for the previous cycle's address |
| instr | output | 16 | Instruction at the execute stage, NOP when not valid |
| instrPc | output | 9 | Word address of the instruction at the execute stage |
| instrValid | output | 1 | Execute-stage instruction is real (not a bubble) |

## Verification
The checker watches several properties on every cycle. The prefetch address stays one ahead of the executing instruction. Sequential issue steps by one with wraparound. A redirect is always followed by a NOP bubble. Stalls freeze the execute-stage outputs. Redirect targets, both relative and absolute, reach the memory address. The bench scenarios are needed to show the contents: that the word presented really is the memory word at the expected address. They also show the full timing from reset, the large-offset wrap cases, the priority of an absolute load over a relative one, and redirects ignored during a bubble or a stall.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  // Strobes from the control to the datapath, one cycle's decision.
  typedef struct packed {
    logic hold;      // freeze PC, execute-stage PC and valid flag
    logic redirect;  // load the fetch PC with a target and flush
    logic useAbs;    // target is the absolute address, not the relative sum
    logic advance;   // normal sequential step
  } ifu_ctl_t;

endpackage

// File: rtl/ifu_ctrl.sv
module ifu_ctrl
  import ifu_pkg::*;
(
  input  logic     stall,
  input  logic     brTaken,
  input  logic     absLoad,
  input  logic     curValid,
  output ifu_ctl_t ctl
);

  logic wantJump;

  // A redirect is only honoured from a real instruction that is not stalled.
  assign wantJump = (brTaken | absLoad) & curValid;

  always_comb begin
    ctl          = '0;
    ctl.hold     = stall;
    ctl.redirect = ~stall & wantJump;
    ctl.useAbs   = absLoad;
    ctl.advance  = ~stall & ~wantJump;
  end

endmodule

// File: rtl/ifu_dp.sv
module ifu_dp
  import ifu_pkg::*;
#(
  parameter int PC_W   = 9,
  parameter int INSN_W = 16,
  parameter int OFF_W  = 12,
  parameter logic [INSN_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ifu_ctl_t          ctl,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic [PC_W-1:0]   absAddr,
  input  logic [INSN_W-1:0] imemData,
  output logic [PC_W-1:0]   imemAddr,
  output logic [INSN_W-1:0] instr,
  output logic [PC_W-1:0]   instrPc,
  output logic              instrValid
);

  logic [PC_W-1:0] fetchPc;   // address being prefetched
  logic [PC_W-1:0] curPc;     // address of the executing word
  logic            curValid;
  logic [PC_W-1:0] offMod;    // offset reduced modulo the program space
  logic [PC_W-1:0] relTarget;
  logic [PC_W-1:0] target;

  // Offset reduction: wider offsets simply drop bits above the PC width,
  // narrower ones are sign-extended. Both are exact modulo 2**PC_W.
  generate
    if (OFF_W >= PC_W) begin : g_trunc
      assign offMod = brOffset[PC_W-1:0];
      if (OFF_W > PC_W) begin : g_hi
        logic unusedOffHi;
        assign unusedOffHi = ^brOffset[OFF_W-1:PC_W];
      end
    end else begin : g_sext
      assign offMod = {{(PC_W-OFF_W){brOffset[OFF_W-1]}}, brOffset};
    end
  endgenerate

  assign relTarget = curPc + PC_W'(1) + offMod;
  assign target    = ctl.useAbs ? absAddr : relTarget;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetchPc  <= '0;
      curPc    <= '0;
      curValid <= 1'b0;
    end else if (ctl.redirect) begin
      fetchPc  <= target;
      curValid <= 1'b0;
    end else if (ctl.advance) begin
      curPc    <= fetchPc;
      fetchPc  <= fetchPc + PC_W'(1);
      curValid <= 1'b1;
    end
  end

  // During a stall the memory re-reads the executing word so that its
  // output, which is the execute-stage instruction, does not move.
  assign imemAddr   = ctl.hold ? curPc : fetchPc;
  assign instr      = curValid ? imemData : NOP_WORD;
  assign instrPc    = curPc;
  assign instrValid = curValid;

endmodule

// File: rtl/ifu_top.sv
module ifu_top
  import ifu_pkg::*;
#(
  parameter int PC_W   = 9,
  parameter int INSN_W = 16,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              brTaken,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic              absLoad,
  input  logic [PC_W-1:0]   absAddr,
  output logic [PC_W-1:0]   imemAddr,
  input  logic [INSN_W-1:0] imemData,
  output logic [INSN_W-1:0] instr,
  output logic [PC_W-1:0]   instrPc,
  output logic              instrValid
);

  ifu_ctl_t ctl;

  ifu_ctrl u_ctrl (
    .stall    (stall),
    .brTaken  (brTaken),
    .absLoad  (absLoad),
    .curValid (instrValid),
    .ctl      (ctl)
  );

  ifu_dp #(
    .PC_W     (PC_W),
    .INSN_W   (INSN_W),
    .OFF_W    (OFF_W),
    .NOP_WORD ('0)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .brOffset   (brOffset),
    .absAddr    (absAddr),
    .imemData   (imemData),
    .imemAddr   (imemAddr),
    .instr      (instr),
    .instrPc    (instrPc),
    .instrValid (instrValid)
  );

endmodule

// File: rtl/ifu_chk.sv
module ifu_chk #(
  parameter int PC_W   = 9,
  parameter int INSN_W = 16,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              brTaken,
  input logic [OFF_W-1:0]  brOffset,
  input logic              absLoad,
  input logic [PC_W-1:0]   absAddr,
  input logic [PC_W-1:0]   imemAddr,
  input logic [INSN_W-1:0] instr,
  input logic [PC_W-1:0]   instrPc,
  input logic              instrValid
);

  logic [PC_W-1:0] relGoal;
  assign relGoal = PC_W'(instrPc + PC_W'(1) + PC_W'(brOffset));

  // R1
  reset_bubble_chk: assert property (@(posedge clk)
    !rst_n |=> !instrValid);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && instrValid && !brTaken && !absLoad)
      |=> (instrValid && instrPc == PC_W'($past(instrPc) + PC_W'(1))));

  // R3
  prefetch_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && instrValid) |-> imemAddr == PC_W'(instrPc + PC_W'(1)));

  // R4
  rel_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && instrValid && brTaken && !absLoad)
      |=> (stall || imemAddr == $past(relGoal)));

  // R5
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && instrValid && (brTaken || absLoad)) |=> !instrValid);

  // R5
  nop_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instrValid |-> instr == '0);

  // R6
  abs_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && instrValid && absLoad)
      |=> (stall || imemAddr == $past(absAddr)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(instrPc) && $stable(instrValid)));

endmodule

bind ifu_top ifu_chk #(
  .PC_W   (PC_W),
  .INSN_W (INSN_W),
  .OFF_W  (OFF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .brTaken    (brTaken),
  .brOffset   (brOffset),
  .absLoad    (absLoad),
  .absAddr    (absAddr),
  .imemAddr   (imemAddr),
  .instr      (instr),
  .instrPc    (instrPc),
  .instrValid (instrValid)
);

// File: tb/sim_ifu_top.sv
`timescale 1ns/1ps
module sim_ifu_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        brTaken = 1'b0;
  logic [11:0] brOffset = '0;
  logic        absLoad = 1'b0;
  logic [8:0]  absAddr = '0;
  logic [8:0]  imemAddr;
  logic [15:0] imemData = '0;
  logic [15:0] instr;
  logic [8:0]  instrPc;
  logic        instrValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ifu_top u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .brTaken(brTaken),
    .brOffset(brOffset), .absLoad(absLoad), .absAddr(absAddr),
    .imemAddr(imemAddr), .imemData(imemData), .instr(instr),
    .instrPc(instrPc), .instrValid(instrValid)
  );

  function automatic logic [15:0] memWord(input logic [8:0] a);
    return {1'b1, a[5:0], a};
  endfunction

  // Program memory, synchronous read, one cycle latency.
  always_ff @(posedge clk) imemData <= memWord(imemAddr);

  typedef struct {
    logic        v;
    logic [8:0]  pc;
    logic [15:0] ins;
    logic [8:0]  addr;
    logic        chkAddr;
    logic [31:0] tag;
  } exp_t;

  exp_t q[$];

  // Bench's expectation state, kept from the requirements.
  logic [8:0] mPc = '0;
  logic [8:0] mNext = '0;
  logic       mValid = 1'b0;

  task automatic cmp(input logic [31:0] tag, input logic [63:0] what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle's inputs, push what the outputs must show now,
  // then advance the expectation by the requirement rules.
  task automatic cyc(input logic st, input logic br, input logic [11:0] off,
                     input logic ab, input logic [8:0] aa, input logic [31:0] tag);
    exp_t e;
    stall = st; brTaken = br; brOffset = off; absLoad = ab; absAddr = aa;
    e.v       = mValid;
    e.pc      = mPc;
    e.ins     = mValid ? memWord(mPc) : 16'h0000;
    e.addr    = st ? mPc : mNext;
    e.chkAddr = !(st && !mValid);
    e.tag     = tag;
    q.push_back(e);
    if (!st) begin
      if (mValid && (ab || br)) begin
        mNext  = ab ? aa : 9'(mPc + 9'd1 + 9'(off));
        mValid = 1'b0;
      end else begin
        mPc    = mNext;
        mNext  = 9'(mNext + 9'd1);
        mValid = 1'b1;
      end
    end
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic [31:0] tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 12'h000, 1'b0, 9'h000, tag);
  endtask

  // Monitor: compare outputs against the queue away from the clock edge.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp(e.tag, "valid", {15'h0, instrValid}, {15'h0, e.v});
        cmp(e.tag, "instr", instr, e.ins);
        if (e.v) cmp(e.tag, "pc", {7'h0, instrPc}, {7'h0, e.pc});
        if (e.chkAddr) cmp(e.tag, "addr", {7'h0, imemAddr}, {7'h0, e.addr});
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset held, no valid instruction
    #1;
    cmp("R1", "rstval", {15'h0, instrValid}, 16'h0000);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 9'h000, "R1");
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 9'h000, "R1");
    run(5, "R2");
    run(3, "R3");
    // R4: forward, backward and self-target relative jumps
    cyc(1'b0, 1'b1, 12'd5, 1'b0, 9'h000, "R4");
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 9'h000, "R5");
    run(2, "R4");
    cyc(1'b0, 1'b1, 12'hFFD, 1'b0, 9'h000, "R4");
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 9'h000, "R5");
    run(2, "R4");
    // R9: offsets that wrap the program space
    cyc(1'b0, 1'b1, 12'hFFF, 1'b0, 9'h000, "R9");
    run(2, "R9");
    cyc(1'b0, 1'b1, 12'h7FF, 1'b0, 9'h000, "R9");
    run(2, "R9");
    cyc(1'b0, 1'b1, 12'h800, 1'b0, 9'h000, "R9");
    run(2, "R9");
    cyc(1'b0, 1'b1, 12'h200, 1'b0, 9'h000, "R9");
    run(2, "R9");
    // R6: absolute load beats a simultaneous relative jump
    cyc(1'b0, 1'b1, 12'd40, 1'b1, 9'd510, "R6");
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 9'h000, "R5");
    // R2: wrap from 511 to 0
    run(4, "R2");
    // R7: stall with redirect strobes asserted, then resume
    cyc(1'b1, 1'b1, 12'd9, 1'b0, 9'h000, "R7");
    cyc(1'b1, 1'b0, 12'h000, 1'b1, 9'd100, "R7");
    cyc(1'b1, 1'b0, 12'h000, 1'b0, 9'h000, "R7");
    run(3, "R7");
    // R8: redirect strobes during a bubble are ignored
    cyc(1'b0, 1'b0, 12'h000, 1'b1, 9'd300, "R6");
    cyc(1'b0, 1'b1, 12'd77, 1'b1, 9'd20, "R8");
    run(3, "R8");
    // R7: stall inside a bubble
    cyc(1'b0, 1'b1, 12'hF00, 1'b0, 9'h000, "R4");
    cyc(1'b1, 1'b0, 12'h000, 1'b0, 9'h000, "R7");
    cyc(1'b1, 1'b1, 12'd3, 1'b0, 9'h000, "R7");
    run(3, "R7");
    cyc(1'b0, 1'b0, 12'h000, 1'b0, 9'h000, "R3");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule